// File: doc/BRIEF.md
# Multi-Format Signed Comparator

This block compares two words, X and Y, as signed numbers in one of three encodings, which a two-bit format input selects. The encodings are sign-magnitude, two's complement and a floating-point layout of sign, biased exponent and mantissa. The result appears on two flags: one is high when X is greater, and the other is high when X is smaller. When both flags are low, the operands are equal. The block is purely combinational.

A single unsigned comparator looks at every bit below the sign. A small resolution stage then takes the two sign bits and that unsigned verdict and produces the final flags. Only the resolution stage depends on the selected format.

In floating-point mode, the exponent and mantissa are compared together as one unsigned key. This works because a biased exponent placed above the mantissa sorts in the same order as the magnitude. Infinity and NaN receive no special treatment.

Top module: `fmt_compare`

## Requirements
- R1: The sign bit is bit WIDTH-1. In every format, when the signs differ and the operands are not a pair of zeros in a sign-magnitude or floating-point format, a cleared sign on X gives X>Y and a set sign on X gives X<Y.
- R2: With fmt_i = 01 (two's complement) and matching signs, the flags equal an unsigned comparison of bits WIDTH-2..0.
- R3: With fmt_i = 00 (sign-magnitude) and both signs 0, a larger low-bit magnitude means the larger value.
- R4: With fmt_i = 00 and both signs 1, a larger magnitude means the smaller value, so the two flags are swapped.
- R5: With fmt_i = 00 or 10, two operands whose bits below the sign are all zero compare equal (both flags 0), whatever their signs.
- R6: With fmt_i = 10 (floating point), the ordering is sign first, then exponent and mantissa taken together as one unsigned field, with the same swap for negative operands as in R4.
- R7: fmt_i = 11 gives the same result as 01.
- R8: gt_o and lt_o are never high together, and identical operands give both flags low in every format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | Left operand X |
| y_i | input | WIDTH | Right operand Y |
| fmt_i | input | 2 | Format: 00 sign-magnitude, 01 two's complement, 10 floating point, 11 two's complement |
| gt_o | output | 1 | High when X > Y |
| lt_o | output | 1 | High when X < Y |

## Verification
The assertions inside the top module are checked on every input change. They cover four properties: the two flags are mutually exclusive, differing signs decide the order, paired zeros compare equal in the sign-magnitude and floating-point formats, and the two's-complement formats pass the unsigned verdict through unchanged. Some behaviour can only be shown by the bench's directed scenarios, because it needs a numeric reference for the expected order. This covers the swapped order for two negative sign-magnitude or floating-point operands, the ordering of real half-width floating-point values, the equality of code 11 with code 01, and a swept set of operand pairs checked against that numeric model.

// File: rtl/fmtcmp_pkg.sv
package fmtcmp_pkg;
   typedef enum logic [1:0] {
      FMT_SIGNMAG  = 2'b00,
      FMT_TWOS     = 2'b01,
      FMT_FLOAT    = 2'b10,
      FMT_TWOS_ALT = 2'b11
   } fmt_e;

   localparam int MAG_CHAIN    = 0;
   localparam int MAG_OPERATOR = 1;
endpackage

// File: rtl/fmtcmp_mag.sv
module fmtcmp_mag #(
   parameter int MW   = 15,
   parameter int ARCH = 0
) (
   input  logic [MW-1:0] a_i,
   input  logic [MW-1:0] b_i,
   output logic          gt_o,
   output logic          lt_o,
   output logic          zz_o
);
   import fmtcmp_pkg::*;

   generate
      if (MW < 1) begin : g_bad_width
         $error("fmtcmp_mag: MW must be at least 1");
      end
      if (ARCH != MAG_CHAIN && ARCH != MAG_OPERATOR) begin : g_bad_arch
         $error("fmtcmp_mag: unknown ARCH");
      end

      if (ARCH == MAG_CHAIN) begin : g_chain
         always_comb begin
            logic g, l;
            g = 1'b0;
            l = 1'b0;
            for (int i = MW - 1; i >= 0; i--) begin
               if (!g && !l) begin
                  g = a_i[i] & ~b_i[i];
                  l = ~a_i[i] & b_i[i];
               end
            end
            gt_o = g;
            lt_o = l;
         end
      end else begin : g_operator
         assign gt_o = a_i > b_i;
         assign lt_o = a_i < b_i;
      end
   endgenerate

   assign zz_o = ~|{a_i, b_i};
endmodule

// File: rtl/fmtcmp_resolve.sv
module fmtcmp_resolve (
   input  fmtcmp_pkg::fmt_e fmt_i,
   input  logic             sx_i,
   input  logic             sy_i,
   input  logic             mgt_i,
   input  logic             mlt_i,
   input  logic             zz_i,
   output logic             gt_o,
   output logic             lt_o
);
   import fmtcmp_pkg::*;

   always_comb begin
      gt_o = 1'b0;
      lt_o = 1'b0;
      case (fmt_i)
         FMT_TWOS, FMT_TWOS_ALT: begin
            if (sx_i != sy_i) begin
               gt_o = sy_i;
               lt_o = sx_i;
            end else begin
               gt_o = mgt_i;
               lt_o = mlt_i;
            end
         end
         default: begin
            if (zz_i) begin
               gt_o = 1'b0;
               lt_o = 1'b0;
            end else if (sx_i != sy_i) begin
               gt_o = sy_i;
               lt_o = sx_i;
            end else if (sx_i) begin
               gt_o = mlt_i;
               lt_o = mgt_i;
            end else begin
               gt_o = mgt_i;
               lt_o = mlt_i;
            end
         end
      endcase
   end
endmodule

// File: rtl/fmt_compare.sv
module fmt_compare #(
   parameter int WIDTH    = 16,
   parameter int MAG_ARCH = 0
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic [1:0]       fmt_i,
   output logic             gt_o,
   output logic             lt_o
);
   import fmtcmp_pkg::*;

   localparam int MW = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("fmt_compare: WIDTH must be at least 2");
      end
   endgenerate

   logic    sx, sy, mgt, mlt, zz;
   fmt_e    fmt;

   assign sx  = x_i[WIDTH-1];
   assign sy  = y_i[WIDTH-1];
   assign fmt = fmt_e'(fmt_i);

   fmtcmp_mag #(.MW(MW), .ARCH(MAG_ARCH)) u_mag (
      .a_i  (x_i[MW-1:0]),
      .b_i  (y_i[MW-1:0]),
      .gt_o (mgt),
      .lt_o (mlt),
      .zz_o (zz)
   );

   fmtcmp_resolve u_resolve (
      .fmt_i (fmt),
      .sx_i  (sx),
      .sy_i  (sy),
      .mgt_i (mgt),
      .mlt_i (mlt),
      .zz_i  (zz),
      .gt_o  (gt_o),
      .lt_o  (lt_o)
   );

   always_comb begin
      AST_FLAGS_EXCLUSIVE: assert (!(gt_o && lt_o)) else $error("both flags high"); // R8
      if (sx != sy && !(!fmt_i[0] && zz)) begin
         AST_SIGN_DECIDES: assert (gt_o == sy && lt_o == sx) else $error("sign order broken"); // R1
      end
      if (!fmt_i[0] && zz) begin
         AST_ZERO_PAIR_EQ: assert (!gt_o && !lt_o) else $error("signed zeros differ"); // R5
      end
      if (fmt_i[0] && sx == sy) begin
         AST_TWOS_PASS: assert (gt_o == mgt && lt_o == mlt) else $error("two's pass-through broken"); // R2
      end
   end
endmodule

// File: tb/fmt_compare_bench.sv
module fmt_compare_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic [W-1:0] x, y;
   logic [1:0]   f;
   logic         gt, lt;
   int           n_vec = 0;
   int           n_bad = 0;
   logic [15:0]  lfsr = 16'hACE1;

   always #4 clk = ~clk;

   fmt_compare #(.WIDTH(W)) u_fmt_compare (
      .x_i(x), .y_i(y), .fmt_i(f), .gt_o(gt), .lt_o(lt)
   );

   function automatic logic [1:0] model(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] m);
      int va, vb;
      if (m[0]) begin
         va = int'($signed(a));
         vb = int'($signed(b));
      end else begin
         va = a[W-1] ? -int'(a[W-2:0]) : int'(a[W-2:0]);
         vb = b[W-1] ? -int'(b[W-2:0]) : int'(b[W-2:0]);
      end
      return {va > vb, va < vb};
   endfunction

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [1:0] m, input logic [1:0] exp, input string req);
      @(negedge clk);
      x = a; y = b; f = m;
      @(posedge clk);
      #1;
      n_vec++;
      if ({gt, lt} !== exp) begin
         n_bad++;
         $display("FAIL %s x=%h y=%h fmt=%b got gt/lt=%b%b expected %b%b",
                  req, a, b, m, gt, lt, exp[1], exp[0]);
      end
   endtask

   task automatic t_idle;
      apply(16'h0000, 16'h0000, 2'b00, 2'b00, "R8 idle");
   endtask

   task automatic t_sign_differs;
      for (int m = 0; m < 4; m++) begin
         apply(16'h0001, 16'h8005, 2'(m), 2'b10, "R1");
         apply(16'hFFFF, 16'h0000, 2'(m), 2'b01, "R1");
      end
   endtask

   task automatic t_twos;
      apply(16'hFFFE, 16'hFFFF, 2'b01, 2'b01, "R2");
      apply(16'h7000, 16'h0FFF, 2'b01, 2'b10, "R2");
      apply(16'h8000, 16'hFFFF, 2'b01, 2'b01, "R2");
   endtask

   task automatic t_sm_pos;
      apply(16'h0123, 16'h0122, 2'b00, 2'b10, "R3");
      apply(16'h0001, 16'h7FFF, 2'b00, 2'b01, "R3");
   endtask

   task automatic t_sm_neg;
      apply(16'h8123, 16'h8122, 2'b00, 2'b01, "R4");
      apply(16'h8001, 16'hFFFF, 2'b00, 2'b10, "R4");
   endtask

   task automatic t_zeros;
      apply(16'h0000, 16'h8000, 2'b00, 2'b00, "R5");
      apply(16'h8000, 16'h0000, 2'b10, 2'b00, "R5");
      apply(16'h8000, 16'h0000, 2'b01, 2'b01, "R5 twos contrast");
   endtask

   task automatic t_float;
      apply(16'h3C00, 16'h4000, 2'b10, 2'b01, "R6 1.0<2.0");
      apply(16'hBC00, 16'hC000, 2'b10, 2'b10, "R6 -1.0>-2.0");
      apply(16'h3BFF, 16'h3C00, 2'b10, 2'b01, "R6 mantissa carry");
      apply(16'hC000, 16'h3C00, 2'b10, 2'b01, "R6 -2<1");
   endtask

   task automatic t_alt_code;
      apply(16'hFFFE, 16'hFFFF, 2'b11, model(16'hFFFE, 16'hFFFF, 2'b01), "R7");
      apply(16'h8001, 16'h8002, 2'b11, 2'b01, "R7");
   endtask

   task automatic t_sweep;
      for (int i = 0; i < 200; i++) begin
         logic [W-1:0] a, b;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = lfsr;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         b = (i % 7 == 0) ? a : lfsr;
         apply(a, b, 2'(i), model(a, b, 2'(i)), "R8 sweep");
      end
   endtask

   initial begin
      fork
         begin
            repeat (100000) @(posedge clk);
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
         end
      join_none
      x = '0; y = '0; f = '0;
      repeat (2) @(posedge clk);
      t_idle;
      t_sign_differs;
      t_twos;
      t_sm_pos;
      t_sm_neg;
      t_zeros;
      t_float;
      t_alt_code;
      t_sweep;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule